// File: doc/BRIEF.md
# Load/Store Address Generator

This block turns the addressing fields of a load or store instruction word into the address that goes to memory. It also produces the value and enable for an optional update of the base register. Four addressing formats are selected by a format input:

- a short format whose 5-bit field holds either an index register number or a small displacement;
- a long 14-bit displacement with no update;
- a long 14-bit displacement with update;
- a word-scaled long displacement with update.

In the short format, an index value can be scaled by the access size. Every displacement keeps its sign bit at the least significant end of its field. In the short format, a direction bit picks between pre-modify and post-modify. In the long formats, the sign of the displacement picks it. The two long update formats map the sign in opposite ways.

The caller supplies the base and index register values along with the instruction word, the access size, and a load/store flag. One cycle later the block presents, all registered:

- the memory address;
- the base write-back value, its enable, and the base register number;
- the data register number.

When a load updates its own base register, the write-back is withheld so that the loaded data wins.

Top module: `ls_addr_gen`

## Requirements
- R1: Outputs are registered. `out_valid` is high exactly one cycle after a cycle with `in_valid` high, and low otherwise. Reset drives `out_valid`, `wb_en` and `mem_addr` to 0.
- R2: Short format (`form`=0) with `insn[12]`=0 is indexed. The offset is `index_val` shifted left by `acc_size`, or unshifted when `insn[13]`=0. `acc_size` codes 0..3 mean byte, halfword, word, doubleword.
- R3: Short format with `insn[12]`=1 uses a 5-bit displacement in `insn[20:16]`. Its sign is `insn[16]` and its magnitude is `insn[20:17]`, so the value is magnitude − 16·sign.
- R4: Short format update rules. With `insn[5]`=0 there is no update. With `insn[5]`=1, the displacement variant is pre-modify when `insn[13]`=1 and post-modify when `insn[13]`=0. The indexed variant is always post-modify.
- R5: `form`=1 and `form`=2 use a 14-bit displacement equal to `insn[13:1]` − 8192·`insn[0]`. `form`=1 never updates. `form`=2 is pre-modify for a negative displacement and post-modify otherwise.
- R6: `form`=3 uses a displacement of 4·(`insn[12:2]` − 2048·`insn[0]`). It is post-modify for a negative displacement and pre-modify otherwise.
- R7: With no update or pre-modify, `mem_addr` is base + offset. With post-modify, `mem_addr` is the unmodified base. `wb_val` is always base + offset, modulo 2^32. `wb_en` is high only for an update.
- R8: For a load (`is_store`=0) with an update whose data register equals its base register, `wb_en` stays low. `mem_addr` is unaffected.
- R9: `wb_reg` is `insn[25:21]`. `tgt_reg` is `insn[4:0]` in the short format and `insn[20:16]` in the long formats.
- R10: In a cycle with `in_valid` low, `mem_addr`, `wb_val`, `wb_reg` and `tgt_reg` keep their previous values and `wb_en` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| form | input | 2 | Addressing format: 0 short, 1 long, 2 long update, 3 word update |
| is_store | input | 1 | 1 for a store, 0 for a load |
| acc_size | input | 2 | Access size code used for index scaling |
| insn | input | 32 | Instruction word |
| base_val | input | 32 | Base register value |
| index_val | input | 32 | Index register value |
| out_valid | output | 1 | Registered result valid |
| mem_addr | output | 32 | Address sent to memory |
| wb_val | output | 32 | Updated base value |
| wb_en | output | 1 | Base write-back enable |
| wb_reg | output | 5 | Base register number |
| tgt_reg | output | 5 | Data register number |

## Verification
Every result is due exactly one clock edge after its request. A request is driven on a falling edge and captured on the next rising edge, and its outputs are compared on the falling edge after that. That same falling edge also applies the next request, so the sweep runs back to back with a steady one-cycle offset. The hold behaviour with `in_valid` low is compared one cycle after the idle cycle, against the outputs of the last accepted request. The reset values are compared while reset is still asserted.

// File: rtl/ls_addr_gen_pkg.sv
package ls_addr_gen_pkg;

    typedef enum logic [1:0] {
        FORM_SHORT    = 2'd0,
        FORM_LONG     = 2'd1,
        FORM_LONG_MOD = 2'd2,
        FORM_WORD_MOD = 2'd3
    } form_e;

    typedef enum logic [1:0] {
        UPD_NONE = 2'd0,
        UPD_PRE  = 2'd1,
        UPD_POST = 2'd2
    } upd_e;

    localparam int REG_W      = 5;
    localparam int INSN_W     = 32;
    localparam int BIT_UPD    = 5;
    localparam int BIT_IMM    = 12;
    localparam int BIT_DIR    = 13;
    localparam int FLD_LO     = 16;
    localparam int FLD_HI     = 20;
    localparam int BREG_LO    = 21;
    localparam int BREG_HI    = 25;
    localparam int SHORT_MAG  = 4;
    localparam int LONG_MAG   = 13;
    localparam int WORD_MAG   = 11;
    localparam int WORD_SHIFT = 2;

endpackage

// File: rtl/ls_field_decode.sv
module ls_field_decode
    import ls_addr_gen_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [INSN_W-1:0] insn,
    input  logic [1:0]        form,
    input  logic [1:0]        acc_size,
    input  logic [XLEN-1:0]   index_val,
    output logic [XLEN-1:0]   offset,
    output upd_e              upd,
    output logic [REG_W-1:0]  tgt_reg,
    output logic [REG_W-1:0]  base_reg
);

    localparam int SHORT_EXT = XLEN - SHORT_MAG;
    localparam int LONG_EXT  = XLEN - LONG_MAG;
    localparam int WORD_EXT  = XLEN - WORD_MAG - WORD_SHIFT;

    logic [XLEN-1:0] short_disp;
    logic [XLEN-1:0] long_disp;
    logic [XLEN-1:0] word_disp;
    logic [XLEN-1:0] idx_scaled;
    logic [1:0]      scale_sh;
    logic            unused_bits;

    // sign lives at the bottom of every displacement field
    assign short_disp = {{SHORT_EXT{insn[FLD_LO]}}, insn[FLD_HI:FLD_LO+1]};
    assign long_disp  = {{LONG_EXT{insn[0]}}, insn[LONG_MAG:1]};
    assign word_disp  = {{WORD_EXT{insn[0]}}, insn[WORD_MAG+1:2], {WORD_SHIFT{1'b0}}};

    assign scale_sh    = insn[BIT_DIR] ? acc_size : 2'd0;
    assign idx_scaled  = index_val << scale_sh;
    assign unused_bits = ^{insn[INSN_W-1:BREG_HI+1], insn[FLD_LO-1:BIT_DIR+1]};

    assign base_reg = insn[BREG_HI:BREG_LO];

    always_comb begin
        offset  = '0;
        upd     = UPD_NONE;
        tgt_reg = insn[FLD_HI:FLD_LO];
        unique case (form_e'(form))
            FORM_SHORT: begin
                tgt_reg = insn[REG_W-1:0];
                if (insn[BIT_IMM]) begin
                    offset = short_disp;
                    if (insn[BIT_UPD]) begin
                        upd = insn[BIT_DIR] ? UPD_PRE : UPD_POST;
                    end
                end else begin
                    offset = idx_scaled;
                    if (insn[BIT_UPD]) begin
                        upd = UPD_POST;
                    end
                end
            end
            FORM_LONG: begin
                offset = long_disp;
            end
            FORM_LONG_MOD: begin
                offset = long_disp;
                upd    = long_disp[XLEN-1] ? UPD_PRE : UPD_POST;
            end
            FORM_WORD_MOD: begin
                offset = word_disp;
                upd    = word_disp[XLEN-1] ? UPD_POST : UPD_PRE;
            end
            default: begin
                offset = '0;
            end
        endcase
    end

endmodule

// File: rtl/ls_addr_sel.sv
module ls_addr_sel
    import ls_addr_gen_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]  base_val,
    input  logic [XLEN-1:0]  offset,
    input  upd_e             upd,
    input  logic             is_store,
    input  logic [REG_W-1:0] tgt_reg,
    input  logic [REG_W-1:0] base_reg,
    output logic [XLEN-1:0]  mem_addr,
    output logic [XLEN-1:0]  wb_val,
    output logic             wb_en
);

    logic [XLEN-1:0] sum;
    logic            load_wins;

    assign sum       = base_val + offset;
    assign load_wins = !is_store && (tgt_reg == base_reg);

    always_comb begin
        wb_val   = sum;
        mem_addr = (upd == UPD_POST) ? base_val : sum;
        wb_en    = (upd != UPD_NONE) && !load_wins;
    end

endmodule

// File: rtl/ls_addr_gen.sv
module ls_addr_gen
    import ls_addr_gen_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        form,
    input  logic              is_store,
    input  logic [1:0]        acc_size,
    input  logic [INSN_W-1:0] insn,
    input  logic [XLEN-1:0]   base_val,
    input  logic [XLEN-1:0]   index_val,
    output logic              out_valid,
    output logic [XLEN-1:0]   mem_addr,
    output logic [XLEN-1:0]   wb_val,
    output logic              wb_en,
    output logic [REG_W-1:0]  wb_reg,
    output logic [REG_W-1:0]  tgt_reg
);

    typedef struct packed {
        logic             vld;
        logic [XLEN-1:0]  addr;
        logic [XLEN-1:0]  wbv;
        logic             wbe;
        logic [REG_W-1:0] wreg;
        logic [REG_W-1:0] treg;
    } stage_t;

    logic [XLEN-1:0]  dec_offset;
    upd_e             dec_upd;
    logic [REG_W-1:0] dec_tgt;
    logic [REG_W-1:0] dec_base;
    logic [XLEN-1:0]  sel_addr;
    logic [XLEN-1:0]  sel_wbv;
    logic             sel_wbe;
    stage_t           stage_d;
    stage_t           stage_q;

    ls_field_decode #(.XLEN(XLEN)) u_decode (
        .insn      (insn),
        .form      (form),
        .acc_size  (acc_size),
        .index_val (index_val),
        .offset    (dec_offset),
        .upd       (dec_upd),
        .tgt_reg   (dec_tgt),
        .base_reg  (dec_base)
    );

    ls_addr_sel #(.XLEN(XLEN)) u_select (
        .base_val (base_val),
        .offset   (dec_offset),
        .upd      (dec_upd),
        .is_store (is_store),
        .tgt_reg  (dec_tgt),
        .base_reg (dec_base),
        .mem_addr (sel_addr),
        .wb_val   (sel_wbv),
        .wb_en    (sel_wbe)
    );

    always_comb begin
        stage_d     = stage_q;
        stage_d.vld = in_valid;
        stage_d.wbe = 1'b0;
        if (in_valid) begin
            stage_d.addr = sel_addr;
            stage_d.wbv  = sel_wbv;
            stage_d.wbe  = sel_wbe;
            stage_d.wreg = dec_base;
            stage_d.treg = dec_tgt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign out_valid = stage_q.vld;
    assign mem_addr  = stage_q.addr;
    assign wb_val    = stage_q.wbv;
    assign wb_en     = stage_q.wbe;
    assign wb_reg    = stage_q.wreg;
    assign tgt_reg   = stage_q.treg;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid) else $error("valid lost"); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !wb_en)) else $error("idle output"); // R1
    AST_NOUPD_NOWB: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dec_upd == UPD_NONE) |=> !wb_en) else $error("stray wb"); // R4
    AST_POST_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dec_upd == UPD_POST) |=> (mem_addr == $past(base_val)))
        else $error("post addr"); // R7
    AST_PRE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dec_upd == UPD_PRE) |=> (mem_addr == wb_val))
        else $error("pre addr"); // R7
    AST_WB_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> out_valid) else $error("wb without valid"); // R7
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_store && dec_upd != UPD_NONE && dec_tgt == dec_base) |=> !wb_en)
        else $error("load lost priority"); // R8
    AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(mem_addr)) else $error("addr moved"); // R10

endmodule

// File: tb/ls_addr_gen_bench.sv
`timescale 1ns/1ps
module ls_addr_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [1:0]  form;
    logic        is_store;
    logic [1:0]  acc_size;
    logic [31:0] insn;
    logic [31:0] base_val;
    logic [31:0] index_val;
    logic        out_valid;
    logic [31:0] mem_addr;
    logic [31:0] wb_val;
    logic        wb_en;
    logic [4:0]  wb_reg;
    logic [4:0]  tgt_reg;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    ls_addr_gen u_ls_addr_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .form      (form),
        .is_store  (is_store),
        .acc_size  (acc_size),
        .insn      (insn),
        .base_val  (base_val),
        .index_val (index_val),
        .out_valid (out_valid),
        .mem_addr  (mem_addr),
        .wb_val    (wb_val),
        .wb_en     (wb_en),
        .wb_reg    (wb_reg),
        .tgt_reg   (tgt_reg)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // drive one request (caller is at a falling edge), compare one cycle later
    // mode: 0 none, 1 pre, 2 post
    task automatic run_one(input logic [1:0] f, input logic st, input logic [1:0] sz,
                           input logic [31:0] iw, input logic [31:0] b, input logic [31:0] x,
                           input int off, input int mode, input logic [4:0] treg,
                           input string atag);
        logic [31:0] sum;
        logic        exp_wbe;
        in_valid  = 1'b1;
        form      = f;
        is_store  = st;
        acc_size  = sz;
        insn      = iw;
        base_val  = b;
        index_val = x;
        sum       = b + 32'(off);
        exp_wbe   = (mode != 0) && !(!st && treg == iw[25:21]);
        @(negedge clk);
        chk("R1 out_valid", {31'd0, out_valid}, 32'd1);
        chk(atag, mem_addr, (mode == 2) ? b : sum);
        chk("R7 wb_val", wb_val, sum);
        if (!st && treg == iw[25:21] && mode != 0)
            chk("R8 wb_en", {31'd0, wb_en}, {31'd0, exp_wbe});
        else
            chk("R4 R7 wb_en", {31'd0, wb_en}, {31'd0, exp_wbe});
        chk("R9 wb_reg", {27'd0, wb_reg}, {27'd0, iw[25:21]});
        chk("R9 tgt_reg", {27'd0, tgt_reg}, {27'd0, treg});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] lcg;
        rst_n     = 1'b0;
        in_valid  = 1'b0;
        form      = 2'd0;
        is_store  = 1'b0;
        acc_size  = 2'd0;
        insn      = '0;
        base_val  = '0;
        index_val = '0;
        lcg       = 32'h1234_5679;
        repeat (3) @(negedge clk);
        chk("R1 reset out_valid", {31'd0, out_valid}, 32'd0);
        chk("R1 reset wb_en", {31'd0, wb_en}, 32'd0);
        chk("R1 reset mem_addr", mem_addr, 32'd0);
        rst_n = 1'b1;

        // short format: indexed and 5-bit displacement, every field value
        for (int k = 0; k < 2048; k++) begin
            logic [4:0]  fld;
            logic [1:0]  sz;
            logic        b5, b12, b13, st;
            logic [4:0]  breg, treg;
            logic [31:0] iw;
            int          off, mode;
            fld  = k[4:0];
            sz   = k[6:5];
            b5   = k[7];
            b12  = k[8];
            b13  = k[9];
            st   = k[10];
            breg = 5'(k * 7);
            treg = (k % 3 == 0) ? breg : 5'(k + 11);
            lcg  = lcg * 32'd1103515245 + 32'd12345;
            iw   = {6'd0, breg, fld, 2'b00, b13, b12, 4'd0, sz, b5, treg};
            if (b12) begin
                off  = int'(fld[4:1]) - 16 * int'(fld[0]);
                mode = b5 ? (b13 ? 1 : 2) : 0;
                run_one(2'd0, st, sz, iw, lcg, ~lcg, off, mode, treg, "R3 R4 mem_addr");
            end else begin
                logic [31:0] ix;
                ix   = {lcg[15:0], lcg[31:16]};
                off  = int'(ix * (32'd1 << (b13 ? int'(sz) : 0)));
                mode = b5 ? 2 : 0;
                run_one(2'd0, st, sz, iw, lcg, ix, off, mode, treg, "R2 mem_addr");
            end
        end

        // long formats: every 14-bit field value
        for (int f = 1; f < 4; f++) begin
            for (int v = 0; v < 16384; v++) begin
                logic [13:0] fv;
                logic [4:0]  breg, treg;
                logic [31:0] iw;
                logic        st;
                int          off, mode;
                string       tag;
                fv   = 14'(v);
                breg = 5'(v * 13 + f);
                treg = (v % 5 == 0) ? breg : 5'(v + 3);
                st   = v[1];
                lcg  = lcg * 32'd1103515245 + 32'd12345;
                iw   = {6'd0, breg, treg, 2'b00, fv};
                if (f == 3) begin
                    off  = 4 * (int'(fv[12:2]) - 2048 * int'(fv[0]));
                    mode = (off < 0) ? 2 : 1;
                    tag  = "R6 mem_addr";
                end else begin
                    off  = int'(fv[13:1]) - 8192 * int'(fv[0]);
                    mode = (f == 1) ? 0 : ((off < 0) ? 1 : 2);
                    tag  = "R5 mem_addr";
                end
                run_one(2'(f), st, 2'd0, iw, lcg, 32'hDEAD_BEEF, off, mode, treg, tag);
            end
        end

        // idle cycle: outputs hold, valid and enable drop
        begin
            logic [31:0] a0, w0;
            logic [4:0]  r0, t0;
            run_one(2'd2, 1'b1, 2'd0, {6'd0, 5'd9, 5'd4, 2'b00, 14'd40}, 32'h0000_1000,
                    32'd0, 20, 2, 5'd4, "R5 mem_addr");
            a0 = mem_addr; w0 = wb_val; r0 = wb_reg; t0 = tgt_reg;
            in_valid  = 1'b0;
            insn      = 32'hFFFF_FFFF;
            base_val  = 32'h5555_5555;
            form      = 2'd3;
            @(negedge clk);
            chk("R10 hold mem_addr", mem_addr, a0);
            chk("R10 hold wb_val", wb_val, w0);
            chk("R10 hold wb_reg", {27'd0, wb_reg}, {27'd0, r0});
            chk("R10 hold tgt_reg", {27'd0, tgt_reg}, {27'd0, t0});
            chk("R10 wb_en low", {31'd0, wb_en}, 32'd0);
            chk("R1 out_valid low", {31'd0, out_valid}, 32'd0);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule